// File: doc/BRIEF.md
# Hashed Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A global history register holds the outcomes of the most recent conditional branches. That history is XOR-folded with a slice of the branch address to pick one entry in an untagged table of 2-bit saturating counters. The prediction is combinational from the table read. The current history is returned with it, so the pipeline can carry that snapshot down to resolution. When the branch resolves, the update port uses the snapshot to recompute the same index and trains that counter. It also shifts the outcome into the history.

A branch can carry a bypass hint. A hinted branch is always predicted not-taken. When it resolves, it leaves both the counter table and the history untouched, so it takes no slot from other branches. Fetch can also select a static rule for a branch it knows has no trained state. Under that rule a backward branch is predicted taken and a forward branch not-taken. Entries carry no address tag. Two branches that map to the same index share one counter, and the only cost is a possible mispredict.

Top module: `bp_dir_pred`

## Requirements
- R1: When `pd_bypass` is 1, `pd_taken` is 0 whatever the table, the static select and the direction flag hold.
- R2: An update with `up_bypass` = 1 changes no counter and leaves `pd_hist` unchanged.
- R3: `pd_hist` resets to all zeros. Each update with `up_valid` = 1 and `up_bypass` = 0 sets it, on the next clock, to the old history shifted left by one with `up_taken` entering at bit 0.
- R4: The prediction index is `pd_hist` XOR `pd_pc[HIST_W+1:2]`. The update index is `up_hist` XOR `up_pc[HIST_W+1:2]`, taken from the returned snapshot and not from the current history.
- R5: After reset every counter holds 01 (weakly not-taken). A counter predicts taken exactly when its upper bit is 1.
- R6: A non-bypassed update increments the indexed counter on taken and decrements it on not-taken. The counter saturates at 11 and 00.
- R7: When `pd_static` = 1 and `pd_bypass` = 0 on a conditional branch, `pd_taken` equals `pd_backward` (1 = backward displacement) and ignores the table.
- R8: Two addresses whose index bits match read and train the same counter, with no tag comparison.
- R9: An update becomes visible only after the clock edge. A prediction of the same index in the same cycle returns the old counter value.
- R10: When `pd_cond` = 0, `pd_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pc | input | ADDR_W | Fetch address of the branch being predicted |
| pd_cond | input | 1 | Instruction is a conditional branch |
| pd_bypass | input | 1 | Bypass hint: force not-taken, use no state |
| pd_backward | input | 1 | Branch displacement is negative |
| pd_static | input | 1 | Use the static direction rule instead of the table |
| pd_taken | output | 1 | Predicted direction (1 = taken) |
| pd_hist | output | HIST_W | Current global history, returned as the snapshot |
| up_valid | input | 1 | A conditional branch resolved this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_bypass | input | 1 | Resolved branch carried the bypass hint |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| up_hist | input | HIST_W | History snapshot returned with that branch's prediction |

## Verification
A wrong counter value reaches the ports only through `pd_taken`, and only when its upper bit is wrong. A counter that fails to saturate at 11 can therefore stay hidden until one or two more not-taken updates drag it below the threshold. For this reason the bench walks single entries through full saturation and back, probing after every step. A wrong history shows on `pd_hist` one clock after the update. It also moves every later prediction index, so each history error spreads into wrong directions on the entries the bench has trained.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;
    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;

    // Saturating step of a 2-bit confidence counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    // Direction held by a counter: the upper bit.
    function automatic logic ctr_dir(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_hash.sv
module bp_hash #(
    parameter int HIST_W = 8,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    localparam int LO = 2;
    localparam int HI = HIST_W + LO - 1;

    logic unused_pc_bits;

    always_comb begin
        idx = hist ^ pc[HI:LO];
    end

    assign unused_pc_bits = ^{pc[ADDR_W-1:HI+1], pc[LO-1:0]};

endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } ghr_state_t;

    ghr_state_t st_d, st_q;
    logic [HIST_W-1:0] shifted;

    generate
        if (HIST_W == 1) begin : g_single
            assign shifted = shift_bit;
        end else begin : g_multi
            assign shifted = {st_q.hist[HIST_W-2:0], shift_bit};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (shift_en) st_d.hist = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.hist;

    // R3
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(shift_bit));

    // R2
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output bp_pkg::ctr_t     rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    import bp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] ctr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctr[wr_idx] = ctr_step(st_q.ctr[wr_idx], wr_taken);
        rd_ctr = st_q.ctr[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctr <= {DEPTH{CTR_INIT}};
        else        st_q     <= st_d;
    end

    // Capture of the last write, kept only for the checks below.
    logic             chk_wr_q;
    logic             chk_dir_q;
    logic [IDX_W-1:0] chk_idx_q;
    ctr_t             chk_old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_wr_q  <= 1'b0;
            chk_dir_q <= 1'b0;
            chk_idx_q <= '0;
            chk_old_q <= CTR_INIT;
        end else begin
            chk_wr_q  <= wr_en;
            chk_dir_q <= wr_taken;
            chk_idx_q <= wr_idx;
            chk_old_q <= st_q.ctr[wr_idx];
        end
    end

    // R6
    ctr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr_q && chk_dir_q) |-> st_q.ctr[chk_idx_q] >= chk_old_q);

    // R6
    ctr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr_q && !chk_dir_q) |-> st_q.ctr[chk_idx_q] <= chk_old_q);

    // R2
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/bp_dir_pred.sv
module bp_dir_pred #(
    parameter int HIST_W = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pd_pc,
    input  logic              pd_cond,
    input  logic              pd_bypass,
    input  logic              pd_backward,
    input  logic              pd_static,
    output logic              pd_taken,
    output logic [HIST_W-1:0] pd_hist,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_bypass,
    input  logic              up_taken,
    input  logic [HIST_W-1:0] up_hist
);
    import bp_pkg::*;

    logic [HIST_W-1:0] hist_cur;
    logic [HIST_W-1:0] rd_idx;
    logic [HIST_W-1:0] wr_idx;
    ctr_t              rd_ctr;
    logic              train_en;

    assign train_en = up_valid & ~up_bypass;

    bp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (train_en),
        .shift_bit (up_taken),
        .hist      (hist_cur)
    );

    bp_hash #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_rd_hash (
        .pc   (pd_pc),
        .hist (hist_cur),
        .idx  (rd_idx)
    );

    bp_hash #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_wr_hash (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (wr_idx)
    );

    bp_ctr_table #(.IDX_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (train_en),
        .wr_idx   (wr_idx),
        .wr_taken (up_taken)
    );

    always_comb begin
        if (!pd_cond || pd_bypass) pd_taken = 1'b0;
        else if (pd_static)        pd_taken = pd_backward;
        else                       pd_taken = ctr_dir(rd_ctr);
    end

    assign pd_hist = hist_cur;

    // R1
    bypass_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_bypass |-> !pd_taken);

    // R10
    noncond_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_cond |-> !pd_taken);

    // R7
    static_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_cond && !pd_bypass && pd_static) |-> pd_taken == pd_backward);

endmodule

// File: tb/bp_dir_pred_bench.sv
`timescale 1ns/1ps
module bp_dir_pred_bench;
    localparam int HW    = 4;
    localparam int AW    = 16;
    localparam int DEPTH = 1 << HW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] pd_pc;
    logic          pd_cond, pd_bypass, pd_backward, pd_static;
    logic          pd_taken;
    logic [HW-1:0] pd_hist;
    logic          up_valid, up_bypass, up_taken;
    logic [AW-1:0] up_pc;
    logic [HW-1:0] up_hist;

    always #2.5 clk = ~clk;

    bp_dir_pred #(.HIST_W(HW), .ADDR_W(AW)) u_bp_dir_pred (
        .clk(clk), .rst_n(rst_n),
        .pd_pc(pd_pc), .pd_cond(pd_cond), .pd_bypass(pd_bypass),
        .pd_backward(pd_backward), .pd_static(pd_static),
        .pd_taken(pd_taken), .pd_hist(pd_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_bypass(up_bypass),
        .up_taken(up_taken), .up_hist(up_hist)
    );

    int checks = 0;
    int fails  = 0;
    int mdl_ctr [DEPTH];
    logic [HW-1:0] mdl_hist;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Address whose index bits give idx under history h; hi sets unrelated upper bits.
    function automatic logic [AW-1:0] pc_at(input logic [HW-1:0] idx, input logic [HW-1:0] h,
                                            input logic [3:0] hi);
        return {hi, 6'b0, idx ^ h, 2'b00};
    endfunction

    task automatic step(input string req,
                        input logic uv, input logic ub, input logic ut,
                        input logic [AW-1:0] upc, input logic [HW-1:0] uh,
                        input logic pc_c, input logic pb, input logic pbk, input logic pst,
                        input logic [AW-1:0] ppc);
        logic exp;
        logic [HW-1:0] ix;
        @(negedge clk);
        up_valid = uv; up_bypass = ub; up_taken = ut; up_pc = upc; up_hist = uh;
        pd_cond = pc_c; pd_bypass = pb; pd_backward = pbk; pd_static = pst; pd_pc = ppc;
        #1;
        ix  = ppc[HW+1:2] ^ mdl_hist;
        exp = pc_c && !pb && (pst ? pbk : (mdl_ctr[ix] >= 2));
        chk(req, {31'b0, pd_taken}, {31'b0, exp});
        chk("R3 history", {28'b0, pd_hist}, {28'b0, mdl_hist});
        @(posedge clk);
        if (uv && !ub) begin
            ix = upc[HW+1:2] ^ uh;
            if (ut) mdl_ctr[ix] = (mdl_ctr[ix] == 3) ? 3 : mdl_ctr[ix] + 1;
            else    mdl_ctr[ix] = (mdl_ctr[ix] == 0) ? 0 : mdl_ctr[ix] - 1;
            mdl_hist = {mdl_hist[HW-2:0], ut};
        end
    endtask

    // Train index ix with outcome t while probing the same index.
    task automatic train(input string req, input logic [HW-1:0] ix, input logic t);
        step(req, 1, 0, t, pc_at(ix, 4'h3, 0), 4'h3, 1, 0, 0, 0, pc_at(ix, mdl_hist, 0));
    endtask

    task automatic probe(input string req, input logic [HW-1:0] ix, input logic b,
                         input logic bk, input logic st, input logic c, input logic [3:0] hi);
        step(req, 0, 0, 0, '0, '0, c, b, bk, st, pc_at(ix, mdl_hist, hi));
    endtask

    initial begin
        rst_n = 1'b0;
        up_valid = 0; up_bypass = 0; up_taken = 0; up_pc = '0; up_hist = '0;
        pd_cond = 0; pd_bypass = 0; pd_backward = 0; pd_static = 0; pd_pc = '0;
        for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 1;
        mdl_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R5: every entry starts weakly not-taken
        for (int i = 0; i < DEPTH; i++) probe("R5 reset entry", i[HW-1:0], 0, 0, 0, 1, 0);

        // R6: climb past saturation, fall past zero, climb again
        for (int i = 0; i < 5; i++) train("R6 rise", 4'd5, 1);
        for (int i = 0; i < 6; i++) train("R6 fall", 4'd5, 0);
        for (int i = 0; i < 3; i++) train("R6 rise again", 4'd5, 1);
        probe("R6 after rise", 4'd5, 0, 0, 0, 1, 0);

        // R9: same-cycle probe sees old value, next cycle sees new
        train("R9 same cycle old", 4'd7, 1);
        probe("R9 next cycle new", 4'd7, 0, 0, 0, 1, 0);

        // R1: bypass overrides a strongly taken entry and the static rule
        for (int i = 0; i < 3; i++) train("R1 setup", 4'd9, 1);
        probe("R1 bypass table", 4'd9, 1, 0, 0, 1, 0);
        probe("R1 bypass static", 4'd9, 1, 1, 1, 1, 0);

        // R2: bypassed updates leave counter and history alone
        for (int i = 0; i < 4; i++)
            step("R2 bypass update", 1, 1, 1, pc_at(4'd11, 4'h0, 0), 4'h0, 1, 0, 0, 0,
                 pc_at(4'd11, mdl_hist, 0));
        probe("R2 entry unchanged", 4'd11, 0, 0, 0, 1, 0);

        // R8: aliasing addresses share one counter
        for (int i = 0; i < 2; i++)
            step("R8 train", 1, 0, 1, pc_at(4'd3, 4'h6, 4'h0), 4'h6, 0, 0, 0, 0, '0);
        probe("R8 alias read", 4'd3, 0, 0, 0, 1, 4'hA);

        // R4: update index follows the snapshot, not the live history
        step("R4 snapshot", 1, 0, 1, pc_at(4'd12, 4'hF, 0), 4'hF, 0, 0, 0, 0, '0);
        step("R4 snapshot", 1, 0, 1, pc_at(4'd12, 4'hF, 0), 4'hF, 0, 0, 0, 0, '0);
        probe("R4 snapshot read", 4'd12, 0, 0, 0, 1, 0);

        // R7: static rule ignores the table
        probe("R7 forward on taken entry", 4'd9, 0, 0, 1, 1, 0);
        probe("R7 backward on cold entry", 4'd13, 0, 1, 1, 1, 0);

        // R10: non-conditional never predicted taken
        probe("R10 not conditional", 4'd9, 0, 1, 0, 0, 0);

        // Sweep: mixed traffic on both ports
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step("R4 R6 sweep", r[0], (r[3:1] == 0), r[4], {r[15:8], 8'h0} ^ {8'h0, r[23:16]},
                 (r[5] ? mdl_hist : r[27:24]), r[6] | r[7], (r[11:8] == 0), r[28], (r[31:29] == 0),
                 {r[20:9], 4'h0} ^ {12'h0, r[3:0]});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule